// File: doc/BRIEF.md
# Microwire Serial EEPROM Slave Controller

This block is a synthesizable model of a three-wire serial nonvolatile memory device. The pins are a chip select, a serial clock and a serial data input. The serial data output is given as a value plus an output enable, so that the chip pad can build a tristate from them. The block runs on a fast system clock and samples the serial pins as ordinary synchronous inputs. It detects rising serial-clock edges by comparing each sample with the previous one. It holds a 16-kbit array that can be read and programmed one word at a time or all at once.

A host raises chip select and sends a start bit. It then sends a two-bit opcode and an address, and for program commands also a data word. Reads stream words continuously for as long as chip select stays high. Program commands start a self-timed cycle. The host can poll that cycle by lowering and then raising chip select, after which the output reports busy or ready. A write-enable latch and a program-enable pin both have to permit a program command before it takes effect.

Top module: `mw_eeprom`

## Requirements
- R1: The `org` pin selects the word width. With `org`=0 there are 2048 bytes and an 11-bit address. With `org`=1 there are 1024 16-bit words and a 10-bit address. In the x16 mode, word a holds its low byte in byte 2a and its high byte in byte 2a+1.
- R2: While `cs` is high and no start bit has been seen, serial-clock rising edges with `di` low are ignored. A rising edge with `di` high is the start bit.
- R3: After the start bit, bits are sampled on rising serial-clock edges, MSB first: a 2-bit opcode, then the address, then data for writes. The opcodes are READ=10, WRITE=01, ERASE=11 and extended=00. For an extended opcode, the top two address bits choose the command: 11 is enable, 00 is disable, 10 is erase-all and 01 is write-all. Once the frame is complete, further edges are ignored until `cs` goes low.
- R4: After reset the write-enable latch is cleared and every program command is ignored. The enable command sets the latch and the disable command clears it.
- R5: READ works with the latch in either state. On the edge of the last address bit, `do_o` becomes a 0 dummy bit. Each following rising edge shifts out the next word bit, MSB first.
- R6: While `cs` stays high during a READ, the address increments after each word and wraps from the top address to 0. The next word's MSB follows the previous word's LSB directly.
- R7: ERASE and erase-all set the addressed word, or every word, to all ones. WRITE and write-all store the supplied data word.
- R8: An accepted program command makes the block busy for exactly `PROG_CYCLES` system clocks, counted from the rising edge of the last frame bit. The cycle completes without further serial clocks, even if `cs` drops.
- R9: After a program cycle starts, raising `cs` again drives `do_oe`=1 with `do_o`=0 while busy and `do_o`=1 when ready. A start bit clears this status output. Outside reads and status, `do_oe` is 0, including after reset and whenever `cs` is low.
- R10: With `pe` low, no program command takes effect, whatever the latch state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| di | input | 1 | Serial data in |
| org | input | 1 | Word width select: 0 = x8, 1 = x16 |
| pe | input | 1 | Program enable, active high |
| do_o | output | 1 | Serial data out / status value |
| do_oe | output | 1 | Output enable for `do_o` |

## Verification
A corrupted bit counter in the frame receiver misplaces the opcode or the address. This shows on the next read as a wrong dummy bit or as a shifted word, within one frame. A stuck write-enable latch or a faulty program-enable gate shows when the host polls: the ready/busy status appears where no program cycle should have started, or is missing where one should have. A timer of the wrong length moves the busy-to-ready transition away from exactly `PROG_CYCLES` clocks after the last frame bit. A wrong read address register breaks the wrap from the top address to 0 during sequential reads.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_SHIFT,
    RX_READ,
    RX_HALT
  } rx_state_t;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EX_DIS  = 2'b00;
  localparam logic [1:0] EX_WALL = 2'b01;
  localparam logic [1:0] EX_EALL = 2'b10;
  localparam logic [1:0] EX_EN   = 2'b11;

endpackage

// File: rtl/mw_rx.sv
module mw_rx
  import mw_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          di,
  input  logic          sclk_rise,
  input  logic          org,
  input  logic          hold,
  output logic          start_o,
  output logic          cmd_o,
  output logic          rd_go_o,
  output logic          reading_o,
  output logic [1:0]    op_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  localparam int CW = $clog2(AW + DW + 3);

  rx_state_t     state_q;
  logic [CW-1:0] cnt_q, last_a, last_d;
  logic [1:0]    op_q, ext_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] data_q, data_n;
  logic          in_shift, at_last_a, at_last_d, wants_data;

  // index of the last address bit and of the last data bit after the start bit
  assign last_a     = org ? CW'(AW) : CW'(AW + 1);
  assign last_d     = org ? CW'(AW + DW) : CW'(AW + 1 + DW / 2);
  assign addr_n     = {addr_q[AW-2:0], di};
  assign data_n     = {data_q[DW-2:0], di};
  assign ext_n      = org ? addr_n[AW-2:AW-3] : addr_n[AW-1:AW-2];
  assign in_shift   = (state_q == RX_SHIFT) && sclk_rise;
  assign at_last_a  = in_shift && (cnt_q == last_a);
  assign at_last_d  = in_shift && (cnt_q == last_d);
  assign wants_data = (op_q == OP_WRITE) || ((op_q == OP_EXT) && (ext_n == EX_WALL));

  assign rd_go_o   = at_last_a && (op_q == OP_READ);
  assign cmd_o     = (at_last_a && (op_q != OP_READ) && !wants_data) || at_last_d;
  assign start_o   = cs && sclk_rise && di && (state_q == RX_IDLE);
  assign reading_o = (state_q == RX_READ);
  assign op_o      = op_q;
  assign addr_o    = at_last_d ? addr_q : addr_n;
  assign data_o    = data_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (!cs) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
    end else if (sclk_rise) begin
      case (state_q)
        RX_IDLE: if (di && !hold) begin
          state_q <= RX_SHIFT;
          cnt_q   <= '0;
          addr_q  <= '0;
          data_q  <= '0;
        end
        RX_SHIFT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q < CW'(2))        op_q   <= {op_q[0], di};
          else if (cnt_q <= last_a)  addr_q <= addr_n;
          else                       data_q <= data_n;
          if (rd_go_o)     state_q <= RX_READ;
          else if (cmd_o)  state_q <= RX_HALT;
        end
        default: ;
      endcase
    end
  end

  // R2: a low data bit while waiting for a start bit leaves the receiver waiting
  assert_idle_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && (state_q == RX_IDLE) && sclk_rise && !di) |=> (state_q == RX_IDLE));

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int TW = $clog2(CYCLES + 1);

  logic [TW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start)          left_q <= TW'(CYCLES);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);

  // checker: count busy cycles independently of the down-counter
  logic [TW:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen_q <= '0;
    else if (!busy) seen_q <= '0;
    else            seen_q <= seen_q + 1'b1;
  end

  // R8: every busy window lasts exactly CYCLES system clocks
  assert_cycle_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (seen_q == (TW+1)'(CYCLES)));

endmodule

// File: rtl/mw_store.sv
module mw_store #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          org,
  input  logic          we,
  input  logic          all,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rword
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      if (all) begin
        for (int i = 0; i < DEPTH; i++)
          mem[i] <= (org && i[0]) ? wdata[15:8] : wdata[7:0];
      end else if (org) begin
        mem[{waddr[AW-2:0], 1'b1}] <= wdata[15:8];
        mem[{waddr[AW-2:0], 1'b0}] <= wdata[7:0];
      end else begin
        mem[waddr] <= wdata[7:0];
      end
    end
  end

  // word aligned to the MSB so the output shifter always taps bit 15
  assign rword = org ? {mem[{raddr[AW-2:0], 1'b1}], mem[{raddr[AW-2:0], 1'b0}]}
                     : {mem[raddr], 8'h00};

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int MEM_BITS    = 16384,
  parameter int PROG_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic di,
  input  logic org,
  input  logic pe,
  output logic do_o,
  output logic do_oe
);
  localparam int AW = $clog2(MEM_BITS / 8);
  localparam int DW = 16;

  function automatic logic [AW-1:0] fold_addr(input logic [AW-1:0] a, input logic x16);
    return x16 ? {1'b0, a[AW-2:0]} : a;
  endfunction

  function automatic logic [1:0] ext_field(input logic [AW-1:0] a, input logic x16);
    return x16 ? a[AW-2:AW-3] : a[AW-1:AW-2];
  endfunction

  function automatic logic [3:0] last_bit(input logic x16);
    return x16 ? 4'd15 : 4'd7;
  endfunction

  logic          sclk_q, cs_q, sclk_rise, cs_rise;
  logic          start_p, cmd_p, rd_go, reading, busy;
  logic [1:0]    op, ext;
  logic [AW-1:0] cmd_addr, addr_f, rd_addr_q, rd_addr_nx, raddr;
  logic [DW-1:0] cmd_data, wdata, rword, sh_q;
  logic          is_prog, prog_go, wen_q, armed_q, stat_vis_q, do_bit_q;
  logic [3:0]    bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs;
    end
  end

  assign sclk_rise = sclk & ~sclk_q;
  assign cs_rise   = cs & ~cs_q;

  mw_rx #(.AW(AW), .DW(DW)) u_rx (
    .clk, .rst_n, .cs, .di, .sclk_rise, .org,
    .hold(busy), .start_o(start_p), .cmd_o(cmd_p), .rd_go_o(rd_go),
    .reading_o(reading), .op_o(op), .addr_o(cmd_addr), .data_o(cmd_data)
  );

  assign addr_f  = fold_addr(cmd_addr, org);
  assign ext     = ext_field(cmd_addr, org);
  assign is_prog = cmd_p && ((op == OP_WRITE) || (op == OP_ERASE) ||
                             ((op == OP_EXT) && ((ext == EX_EALL) || (ext == EX_WALL))));
  assign prog_go = is_prog && wen_q && pe;
  assign wdata   = ((op == OP_WRITE) || ((op == OP_EXT) && (ext == EX_WALL))) ? cmd_data : '1;

  mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk, .rst_n, .start(prog_go), .busy
  );

  assign rd_addr_nx = fold_addr(rd_addr_q + 1'b1, org);
  assign raddr      = rd_go ? addr_f : rd_addr_nx;

  mw_store #(.AW(AW)) u_store (
    .clk, .org, .we(prog_go), .all(op == OP_EXT), .waddr(addr_f),
    .wdata, .raddr, .rword
  );

  // write-enable latch and ready/busy status phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q      <= 1'b0;
      armed_q    <= 1'b0;
      stat_vis_q <= 1'b0;
    end else begin
      if (cmd_p && (op == OP_EXT) && (ext == EX_EN))       wen_q <= 1'b1;
      else if (cmd_p && (op == OP_EXT) && (ext == EX_DIS)) wen_q <= 1'b0;
      if (prog_go)       armed_q <= 1'b1;
      else if (start_p)  armed_q <= 1'b0;
      if (!cs || start_p)          stat_vis_q <= 1'b0;
      else if (cs_rise && armed_q) stat_vis_q <= 1'b1;
    end
  end

  // read output shifter with address auto-increment
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      sh_q      <= '0;
      bit_q     <= '0;
      do_bit_q  <= 1'b0;
    end else if (rd_go) begin
      rd_addr_q <= addr_f;
      sh_q      <= rword;
      bit_q     <= '0;
      do_bit_q  <= 1'b0;
    end else if (reading && sclk_rise) begin
      do_bit_q <= sh_q[DW-1];
      if (bit_q == last_bit(org)) begin
        sh_q      <= rword;
        rd_addr_q <= rd_addr_nx;
        bit_q     <= '0;
      end else begin
        sh_q  <= {sh_q[DW-2:0], 1'b0};
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign do_oe = stat_vis_q | reading;
  assign do_o  = stat_vis_q ? ~busy : do_bit_q;

  // R5: the cycle after the last address bit of a READ drives a 0 dummy bit
  assert_dummy_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> (do_oe && !do_o));

  // R10 (and R4): a program cycle only begins with pe high and the latch set
  assert_prog_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(pe) && $past(wen_q)));

  // R4: the latch only moves as the result of a completed command frame
  assert_latch_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_q != $past(wen_q)) |-> $past(cmd_p));

  // R9: deselecting the device releases the output on the next clock
  assert_quiet_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !do_oe);

endmodule

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
  localparam int P = 40;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0, org = 1'b0, pe = 1'b1;
  logic do_o, do_oe;

  mw_eeprom #(.MEM_BITS(16384), .PROG_CYCLES(P)) dut (
    .clk, .rst_n, .cs, .sclk, .di, .org, .pe, .do_o, .do_oe
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nvec = 0, nbad = 0, mark = 0;
  logic [7:0] refm [0:2047];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int aw(); return org ? 10 : 11; endfunction
  function automatic int dw(); return org ? 16 : 8;  endfunction
  function automatic int depth(); return org ? 1024 : 2048; endfunction

  function automatic logic [15:0] exp_word(input int a);
    return org ? {refm[2*a+1], refm[2*a]} : {8'h00, refm[a]};
  endfunction

  task automatic ref_put(input int a, input logic [15:0] d);
    if (org) begin refm[2*a] = d[7:0]; refm[2*a+1] = d[15:8]; end
    else refm[a] = d[7:0];
  endtask

  task automatic ref_fill(input logic [15:0] d);
    for (int i = 0; i < 2048; i++) refm[i] = (org && (i % 2 == 1)) ? d[15:8] : d[7:0];
  endtask

  task automatic pulse(input logic b);
    di = b; sclk = 1'b1;
    @(negedge clk); mark = cyc;
    @(negedge clk); sclk = 1'b0;
    tick(2);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask

  // idle: low-data clocks before the start bit (R2)
  task automatic issue(input logic [1:0] op, input int addr, input logic [15:0] data,
                       input bit has_data, input int idle);
    cs = 1'b1; tick(2);
    repeat (idle) pulse(1'b0);
    pulse(1'b1);
    send(32'(op), 2);
    send(32'(addr), aw());
    if (has_data) send(32'(data), dw());
  endtask

  task automatic end_cmd();
    di = 1'b0; cs = 1'b0; tick(3);
  endtask

  function automatic int ext_addr(input int e); return e << (aw() - 2); endfunction

  // poll status after a program command; optionally check the cycle length
  task automatic prog_wait(input string req, input bit timing);
    int n;
    cs = 1'b1; tick(3);
    chk({req, " status busy oe"}, 32'(do_oe), 1);
    chk({req, " status busy value"}, 32'(do_o), 0);
    n = 0;
    while (do_o !== 1'b1 && n < P + 100) begin tick(1); n++; end
    if (timing) chk("R8 busy length", 32'(cyc - mark), 32'(P));
    chk({req, " status ready"}, 32'(do_o), 1);
    pulse(1'b1);
    chk("R9 start bit clears status", 32'(do_oe), 0);
    end_cmd();
  endtask

  task automatic read_check(input string req, input int addr, input int nw);
    int a;
    logic [15:0] got;
    issue(2'b10, addr, 16'h0, 1'b0, 0);
    chk({req, " R5 dummy oe"}, 32'(do_oe), 1);
    chk({req, " R5 dummy bit"}, 32'(do_o), 0);
    a = addr;
    for (int w = 0; w < nw; w++) begin
      got = '0;
      for (int b = 0; b < dw(); b++) begin
        pulse(1'b0);
        got = {got[14:0], do_o};
      end
      chk(req, 32'(got), 32'(exp_word(a)));
      a = (a + 1) % depth();
    end
    end_cmd();
  endtask

  initial begin
    tick(4); rst_n = 1'b1; tick(2);
    chk("R9 reset output released", 32'(do_oe), 0);

    // R4: latch is disabled after reset, so no program cycle starts
    issue(2'b01, 16, 16'h3C, 1'b1, 0); end_cmd();
    cs = 1'b1; tick(3);
    chk("R4 write ignored after reset (no status)", 32'(do_oe), 0);
    cs = 1'b0; tick(2);

    // R3 enable, R7 erase-all (x8), R8 exact busy length
    issue(2'b00, ext_addr(3), 16'h0, 1'b0, 0); end_cmd();
    issue(2'b00, ext_addr(2), 16'h0, 1'b0, 0); end_cmd();
    ref_fill(16'hFFFF);
    prog_wait("R7 erase-all", 1'b1);
    read_check("R7 R4 erased, early write blocked", 16, 2);

    // R2 idle clocks before start, R3 write opcode, R1 x8 addressing
    issue(2'b01, 5, 16'hA5, 1'b1, 3); end_cmd(); ref_put(5, 16'hA5); prog_wait("R3 write", 1'b1);
    issue(2'b01, 2047, 16'h5A, 1'b1, 0); end_cmd(); ref_put(2047, 16'h5A); prog_wait("R1 write top", 1'b0);
    issue(2'b01, 0, 16'hC3, 1'b1, 2); end_cmd(); ref_put(0, 16'hC3); prog_wait("R2 write", 1'b0);
    read_check("R6 sequential wrap x8", 2047, 3);
    read_check("R2 R5 single read", 5, 1);

    // R3: clocks after a complete frame are ignored
    issue(2'b01, 32, 16'h11, 1'b1, 0);
    repeat (4) pulse(1'b1);
    end_cmd(); ref_put(32, 16'h11); prog_wait("R3 trailing clocks", 1'b0);
    read_check("R3 trailing clocks ignored", 32, 2);

    // R7 single erase
    issue(2'b11, 5, 16'h0, 1'b0, 0); end_cmd(); ref_put(5, 16'hFFFF); prog_wait("R7 erase", 1'b0);
    read_check("R7 erase word", 4, 3);

    // R8: cycle completes with cs low and no serial clocks
    issue(2'b01, 48, 16'h77, 1'b1, 0); end_cmd(); ref_put(48, 16'h77);
    tick(P + 10);
    cs = 1'b1; tick(3);
    chk("R8 finished without clocks oe", 32'(do_oe), 1);
    chk("R8 finished without clocks ready", 32'(do_o), 1);
    pulse(1'b1); end_cmd();
    read_check("R8 data after cs drop", 48, 1);

    // R9: start bit during busy clears the status output
    issue(2'b01, 49, 16'h88, 1'b1, 0); end_cmd(); ref_put(49, 16'h88);
    cs = 1'b1; tick(3);
    chk("R9 busy shown", 32'(do_o), 0);
    pulse(1'b1);
    chk("R9 cleared while busy", 32'(do_oe), 0);
    cs = 1'b0; tick(P + 10);

    // R10: pe low blocks programming
    pe = 1'b0;
    issue(2'b01, 49, 16'h00, 1'b1, 0); end_cmd();
    cs = 1'b1; tick(3);
    chk("R10 no program cycle", 32'(do_oe), 0);
    cs = 1'b0; tick(2); pe = 1'b1;
    read_check("R10 word unchanged", 49, 1);

    // R4: disable blocks writes; R5 read still works
    issue(2'b00, ext_addr(0), 16'h0, 1'b0, 0); end_cmd();
    issue(2'b01, 64, 16'h12, 1'b1, 0); end_cmd();
    cs = 1'b1; tick(3);
    chk("R4 disabled write no status", 32'(do_oe), 0);
    cs = 1'b0; tick(2);
    read_check("R4 R5 read with latch off", 64, 1);

    // x16 mode: R1 byte mapping, R6 wrap, R7 write-all
    issue(2'b00, ext_addr(3), 16'h0, 1'b0, 0); end_cmd();
    org = 1'b1;
    issue(2'b01, 3, 16'h1234, 1'b1, 0); end_cmd(); ref_put(3, 16'h1234); prog_wait("R1 x16 write", 1'b0);
    read_check("R6 x16 sequential", 2, 3);
    org = 1'b0;
    read_check("R1 x16 word seen as bytes", 6, 2);
    org = 1'b1;
    issue(2'b00, ext_addr(1), 16'hBEEF, 1'b1, 0); end_cmd(); ref_fill(16'hBEEF);
    prog_wait("R7 write-all", 1'b1);
    read_check("R6 R7 x16 wrap after write-all", 1023, 2);
    org = 1'b0;
    read_check("R1 R7 write-all bytes", 2046, 2);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule